// File: doc/BRIEF.md
# Staggered LED String Dimming Controller

This block turns one external dimming PWM into enables for six LED current sinks. The PWM arrives unsynchronised to the system clock. In direct mode every live string follows the synchronised PWM level. In staggered mode the block measures the input duty and emits it again at its own output period. The period is chosen by a small code. The live strings are spread evenly over that period, so that at any moment only a fraction of them switch.

The block decides which strings are live. It samples the string-open flags at the moment the driver starts and leaves out the strings that read open. It then watches the remaining strings for a long run of zero current and drops any such string for good. If every string reads open while the boost output sits at its overvoltage limit, it shuts everything down. Its boost-disable flag keeps the boost converter off while the driver is idle, after a total shutdown, and until the PWM has been seen high at least once since the driver started. The enable has no effect until an external bias-ready input is high.

Top module: `pwm_dim_ctrl`

## Requirements
- R1: After reset all sink enables are 0 and boost_off is 1.
- R2: The driver runs only while bias_rdy and en are both 1. en has no effect while bias_rdy is 0. While the driver is not running, all sink enables are 0 and boost_off is 1.
- R3: With mode_sel = 0 (direct), every live channel's enable equals pwm_in delayed by three clocks: two synchroniser stages and one output register. All live channels switch together.
- R4: Between two consecutive rising edges of the synchronised PWM, the block counts the high cycles H and the period cycles T. At the second edge the duty becomes floor(H·2^FW / T), with 2^FW = 256 by default. The first edge after a timeout or reset does not update the duty.
- R5: With mode_sel = 1 (staggered), the output period is P = BASE + STEP·fdim_code clock cycles, which is 60 + 4·code by default. A channel of rank 0 is on while the phase counter is below floor(duty·P / 2^FW).
- R6: Live channels are ranked by ascending index. A channel of rank r is delayed by r·floor(P/N) cycles, where N is the number of live channels. The spacing follows N as it changes.
- R7: On the cycle the driver starts, every channel whose ch_open bit is 1 is excluded until the next start. Excluded channels stay 0.
- R8: A live channel whose ch_open bit stays 1 for OPEN_CYC consecutive cycles (32 by default) while running is disabled until reset. Shorter runs have no effect, and restarting the driver does not revive the channel.
- R9: If ovp_hit is 1 and all ch_open bits are 1 while running, all enables go to 0 and boost_off goes to 1 until reset, even across restarts.
- R10: boost_off is 0 only while running, not shut down, and after the synchronised PWM has been seen high since the driver started.
- R11: If no rising edge of the synchronised PWM occurs for 2^MW−1 cycles (1023 by default), the duty is set to full if the PWM is high and to zero if it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | External dimming PWM, asynchronous |
| bias_rdy | input | 1 | Bias rails have finished starting; gates en |
| en | input | 1 | Driver enable |
| mode_sel | input | 1 | 0 = direct, 1 = staggered |
| fdim_code | input | CODEW | Output period code for staggered mode |
| ch_open | input | NCH | Per-string zero-current flags |
| ovp_hit | input | 1 | Boost output at its overvoltage limit |
| sink_en | output | NCH | Current-sink enables |
| boost_off | output | 1 | Keep the boost converter disabled |

## Verification
Two activities can fall in the same cycle. The first is a duty update on a synchronised PWM rising edge. The second is the staggered output's phase compare, including its wrap at the end of the output period. The bench runs input periods of 20, 40 and 50 cycles against output periods of 60 and 80, so the edges drift across every phase position, including the wrap. An open fault that reduces N can also latch while channels are being compared. The reference model advances every register once per clock and is compared on each cycle, so a new duty or a new spacing that takes effect one cycle early or late shows up as a mismatch.

// File: rtl/pwm_dim_pkg.sv
package pwm_dim_pkg;
    typedef enum logic {
        DIM_DIRECT  = 1'b0,
        DIM_STAGGER = 1'b1
    } dim_mode_e;
endpackage

// File: rtl/pwm_dim_meas.sv
// Synchronises the external PWM and measures its duty as a fixed-point ratio.
module pwm_dim_meas #(
    parameter int MW = 10,
    parameter int FW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwm_in,
    output logic        pwm_s,
    output logic [FW:0] duty
);
    localparam int            QW   = MW + FW;
    localparam logic [MW-1:0] PMAX = '1;
    localparam logic [FW:0]   FULL = {1'b1, {FW{1'b0}}};

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          pv;
        logic          armed;
        logic [MW-1:0] per;
        logic [MW-1:0] hi;
        logic [FW:0]   duty;
    } meas_t;

    meas_t         m_q, m_d;
    logic [QW-1:0] quo;
    logic [MW-1:0] div;
    logic          rise;

    always_comb begin
        m_d    = m_q;
        m_d.s1 = pwm_in;
        m_d.s2 = m_q.s1;
        m_d.pv = m_q.s2;
        rise   = m_q.s2 & ~m_q.pv;
        div    = (m_q.per == '0) ? MW'(1) : m_q.per;
        quo    = {m_q.hi, {FW{1'b0}}} / QW'(div);
        if (rise) begin
            if (m_q.armed) m_d.duty = (quo > QW'(FULL)) ? FULL : quo[FW:0];
            m_d.armed = 1'b1;
            m_d.per   = MW'(1);
            m_d.hi    = MW'(1);
        end else if (m_q.per == PMAX) begin
            m_d.duty  = m_q.s2 ? FULL : '0;
            m_d.armed = 1'b0;
            m_d.per   = MW'(1);
            m_d.hi    = MW'(m_q.s2);
        end else begin
            m_d.per = m_q.per + MW'(1);
            m_d.hi  = m_q.hi + MW'(m_q.s2);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign pwm_s = m_q.s2;
    assign duty  = m_q.duty;
endmodule

// File: rtl/pwm_dim_guard.sv
// Decides which strings are live: start-time exclusion, open timers, total shutdown.
module pwm_dim_guard #(
    parameter int NCH      = 6,
    parameter int OPEN_CYC = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           start,
    input  logic [NCH-1:0] ch_open,
    input  logic           ovp_hit,
    output logic [NCH-1:0] live,
    output logic           all_off
);
    localparam int            TW    = $clog2(OPEN_CYC + 1);
    localparam logic [TW-1:0] TLAST = TW'(OPEN_CYC - 1);

    typedef struct packed {
        logic [NCH-1:0]         excl;
        logic [NCH-1:0]         fault;
        logic                   dead;
        logic [NCH-1:0][TW-1:0] tmr;
    } grd_t;

    grd_t g_q, g_d;

    assign live    = ~g_q.excl & ~g_q.fault & {NCH{~g_q.dead}};
    assign all_off = g_q.dead;

    always_comb begin
        g_d = g_q;
        if (start) g_d.excl = ch_open;
        for (int k = 0; k < NCH; k++) begin
            if (run && live[k] && ch_open[k]) begin
                g_d.tmr[k] = g_q.tmr[k] + TW'(1);
                if (g_q.tmr[k] == TLAST) g_d.fault[k] = 1'b1;
            end else begin
                g_d.tmr[k] = '0;
            end
        end
        if (run && ovp_hit && (&ch_open)) g_d.dead = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end
endmodule

// File: rtl/pwm_dim_phase.sv
// Output period counter and staggered compare for every channel.
module pwm_dim_phase #(
    parameter int NCH   = 6,
    parameter int CODEW = 3,
    parameter int BASE  = 60,
    parameter int STEP  = 4,
    parameter int FW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CODEW-1:0] code,
    input  logic [NCH-1:0]   live,
    input  logic [FW:0]      duty,
    output logic [NCH-1:0]   stag
);
    localparam int PMAXV = BASE + STEP * (2 ** CODEW - 1);
    localparam int PW    = $clog2(PMAXV + 1);
    localparam int NW    = $clog2(NCH + 1);
    localparam int XW    = PW + FW + 1;

    typedef struct packed {
        logic [PW-1:0] pc;
    } ph_t;

    ph_t           p_q, p_d;
    logic [PW-1:0] per, off, div;
    logic [NW-1:0] nlive;
    logic [XW-1:0] thr;

    always_comb begin
        per   = PW'(BASE + STEP * int'(code));
        nlive = NW'($countones(live));
        div   = (nlive == '0) ? PW'(1) : PW'(nlive);
        off   = per / div;
        thr   = (XW'(duty) * XW'(per)) >> FW;
        p_d.pc = (p_q.pc >= per - PW'(1)) ? '0 : p_q.pc + PW'(1);
    end

    always_comb begin
        logic [NW-1:0] rank;
        logic [PW:0]   pos;
        rank = '0;
        pos  = '0;
        stag = '0;
        for (int k = 0; k < NCH; k++) begin
            pos = (PW+1)'(p_q.pc) + (PW+1)'(per) - (PW+1)'(PW'(rank) * off);
            if (pos >= (PW+1)'(per)) pos = pos - (PW+1)'(per);
            stag[k] = live[k] & (XW'(pos) < thr);
            if (live[k]) rank = rank + NW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end
endmodule

// File: rtl/pwm_dim_ctrl.sv
module pwm_dim_ctrl
    import pwm_dim_pkg::*;
#(
    parameter int NCH      = 6,
    parameter int CODEW    = 3,
    parameter int BASE     = 60,
    parameter int STEP     = 4,
    parameter int MW       = 10,
    parameter int FW       = 8,
    parameter int OPEN_CYC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_in,
    input  logic             bias_rdy,
    input  logic             en,
    input  logic             mode_sel,
    input  logic [CODEW-1:0] fdim_code,
    input  logic [NCH-1:0]   ch_open,
    input  logic             ovp_hit,
    output logic [NCH-1:0]   sink_en,
    output logic             boost_off
);
    typedef struct packed {
        logic           run;
        logic           seen;
        logic           boff;
        logic [NCH-1:0] sink;
    } top_t;

    top_t           st_q, st_d;
    logic           pwm_s, start, all_off;
    logic [FW:0]    duty;
    logic [NCH-1:0] live, stag;

    assign start = bias_rdy & en & ~st_q.run;

    pwm_dim_meas #(.MW(MW), .FW(FW)) u_meas (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .pwm_s(pwm_s), .duty(duty)
    );

    pwm_dim_guard #(.NCH(NCH), .OPEN_CYC(OPEN_CYC)) u_guard (
        .clk(clk), .rst_n(rst_n), .run(st_q.run), .start(start),
        .ch_open(ch_open), .ovp_hit(ovp_hit), .live(live), .all_off(all_off)
    );

    pwm_dim_phase #(.NCH(NCH), .CODEW(CODEW), .BASE(BASE), .STEP(STEP), .FW(FW)) u_phase (
        .clk(clk), .rst_n(rst_n), .code(fdim_code), .live(live), .duty(duty), .stag(stag)
    );

    always_comb begin
        st_d      = st_q;
        st_d.run  = bias_rdy & en;
        st_d.seen = st_q.run & (st_q.seen | pwm_s);
        st_d.boff = ~(st_q.run & ~all_off & st_q.seen);
        if (!st_q.run)
            st_d.sink = '0;
        else if (dim_mode_e'(mode_sel) == DIM_STAGGER)
            st_d.sink = stag;
        else
            st_d.sink = {NCH{pwm_s}} & live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.boff <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sink_en   = st_q.sink;
    assign boost_off = st_q.boff;
endmodule

// File: rtl/pwm_dim_chk.sv
module pwm_dim_chk #(
    parameter int NCH = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           run_q,
    input logic           seen_q,
    input logic           start,
    input logic           boost_off,
    input logic           all_off,
    input logic [NCH-1:0] sink_en,
    input logic [NCH-1:0] live
);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> (sink_en == '0 && boost_off));

    // R9
    shutdown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_off |=> all_off);

    // R9
    shutdown_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_off |=> (sink_en == '0 && boost_off));

    // R8
    live_no_regain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ((live & ~$past(live)) == '0));

    // R7
    sink_within_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sink_en & ~$past(live)) == '0));

    // R10
    boost_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |=> boost_off);
endmodule

bind pwm_dim_ctrl pwm_dim_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_q(st_q.run), .seen_q(st_q.seen), .start(start),
    .boost_off(boost_off), .all_off(all_off), .sink_en(sink_en), .live(live)
);

// File: tb/test_pwm_dim_ctrl.sv
`timescale 1ns/1ps
module test_pwm_dim_ctrl;
    localparam int NCH = 6, CODEW = 3, BASE = 60, STEP = 4, MW = 10, FW = 8, OPENC = 32;
    localparam int PMAXC = (1 << MW) - 1;
    localparam int ALL = (1 << NCH) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwm_in = 1'b0;
    logic             bias_rdy = 1'b0;
    logic             en = 1'b0;
    logic             mode_sel = 1'b0;
    logic [CODEW-1:0] fdim_code = '0;
    logic [NCH-1:0]   ch_open = '0;
    logic             ovp_hit = 1'b0;
    logic [NCH-1:0]   sink_en;
    logic             boost_off;

    pwm_dim_ctrl #(.NCH(NCH), .CODEW(CODEW), .BASE(BASE), .STEP(STEP), .MW(MW), .FW(FW),
                   .OPEN_CYC(OPENC)) i_pwm_dim_ctrl (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .bias_rdy(bias_rdy), .en(en),
        .mode_sel(mode_sel), .fdim_code(fdim_code), .ch_open(ch_open), .ovp_hit(ovp_hit),
        .sink_en(sink_en), .boost_off(boost_off)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    // PWM stimulus: stuck 0 = periodic, 1 = held low, 2 = held high
    int pwm_per = 20, pwm_hi = 5, pwm_ph = 0, stuck = 0;
    always @(negedge clk) begin
        pwm_ph = (pwm_ph + 1 >= pwm_per) ? 0 : pwm_ph + 1;
        pwm_in = (stuck == 2) ? 1'b1 : (stuck == 1) ? 1'b0 : (pwm_ph < pwm_hi);
    end

    // Behavioural reference model
    int m_s1, m_s2, m_pv, m_armed, m_per, m_hi, m_duty;
    int m_run, m_seen, m_boff, m_sink, m_excl, m_fault, m_dead, m_pc;
    int m_tmr[NCH];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_pv = 0; m_armed = 0; m_per = 0; m_hi = 0; m_duty = 0;
            m_run = 0; m_seen = 0; m_boff = 1; m_sink = 0; m_excl = 0; m_fault = 0;
            m_dead = 0; m_pc = 0;
            foreach (m_tmr[k]) m_tmr[k] = 0;
        end else begin
            int live, p, n, off, thr, rank, pos, stag, req, nfault;
            live = m_dead ? 0 : (~m_excl & ~m_fault & ALL);
            p = BASE + STEP * int'(fdim_code);
            n = $countones(live);
            off = p / ((n == 0) ? 1 : n);
            thr = (m_duty * p) >> FW;
            stag = 0; rank = 0;
            for (int k = 0; k < NCH; k++) begin
                if (live[k]) begin
                    pos = (m_pc + p - rank * off) % p;
                    if (pos < thr) stag |= (1 << k);
                    rank++;
                end
            end
            req = (bias_rdy && en) ? 1 : 0;
            nfault = m_fault;
            for (int k = 0; k < NCH; k++) begin
                if (m_run != 0 && live[k] && ch_open[k]) begin
                    if (m_tmr[k] == OPENC - 1) nfault |= (1 << k);
                    m_tmr[k]++;
                end else m_tmr[k] = 0;
            end
            if (req != 0 && m_run == 0) m_excl = int'(ch_open);
            m_fault = nfault;
            m_sink = (m_run == 0) ? 0 : (mode_sel ? stag : (m_s2 != 0 ? live : 0));
            m_boff = (m_run != 0 && m_dead == 0 && m_seen != 0) ? 0 : 1;
            m_seen = (m_run != 0 && (m_seen != 0 || m_s2 != 0)) ? 1 : 0;
            if (m_run != 0 && ovp_hit && int'(ch_open) == ALL) m_dead = 1;
            m_run = req;
            if (m_s2 != 0 && m_pv == 0) begin
                if (m_armed != 0) m_duty = (m_hi << FW) / m_per;
                m_armed = 1; m_per = 1; m_hi = 1;
            end else if (m_per == PMAXC) begin
                m_duty = (m_s2 != 0) ? (1 << FW) : 0;
                m_armed = 0; m_per = 1; m_hi = m_s2;
            end else begin
                m_per++; m_hi += m_s2;
            end
            m_pc = (m_pc >= p - 1) ? 0 : m_pc + 1;
            m_pv = m_s2; m_s2 = m_s1; m_s1 = pwm_in ? 1 : 0;
        end
    end

    // Per-cycle comparison (R3 direct, R5/R6 staggered, R10 boost flag)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(mode_sel ? "R5/R6 model" : "R3 model", int'(sink_en), m_sink);
            check("R10 model", int'(boost_off), m_boff);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(int ch, int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (sink_en[ch]) c++;
        end
    endtask

    task automatic rise_gap(int a, int b, output int gap);
        logic pa, pb;
        int guard;
        guard = 0;
        @(negedge clk); pa = sink_en[a];
        do begin
            @(negedge clk); guard++;
            if (!pa && sink_en[a]) break;
            pa = sink_en[a];
        end while (guard < 500);
        gap = 0; pb = sink_en[b];
        do begin
            @(negedge clk); gap++;
            if (!pb && sink_en[b]) break;
            pb = sink_en[b];
        end while (gap < 500);
    endtask

    initial begin
        int c, orv, allb, bad;
        wait_cyc(3);
        check("R1 sink in reset", int'(sink_en), 0);
        check("R1 boost in reset", int'(boost_off), 1);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R1 sink after reset", int'(sink_en), 0);

        // R2: en without bias_rdy
        en = 1'b1;
        orv = 0; allb = 1;
        repeat (200) begin
            @(negedge clk);
            orv |= int'(sink_en);
            allb &= int'(boost_off);
        end
        check("R2 sinks idle", orv, 0);
        check("R2 boost held", allb, 1);

        // R3: direct mode, period 20, high 5
        bias_rdy = 1'b1;
        wait_cyc(50);
        check("R10 boost released", int'(boost_off), 0);
        count_high(0, 200, c);
        check("R3 direct high count", c, 50);
        bad = 0;
        repeat (100) begin
            @(negedge clk);
            if (sink_en != '0 && sink_en != NCH'(ALL)) bad++;
        end
        check("R3 channels together", bad, 0);

        // R5/R6: staggered, P=60, duty 64 -> thr 15, spacing 10
        mode_sel = 1'b1; fdim_code = 3'd0; pwm_per = 40; pwm_hi = 10;
        wait_cyc(300);
        count_high(0, 600, c);
        check("R5 staggered on count", c, 150);
        rise_gap(0, 1, c);
        check("R6 spacing N=6", c, 10);

        // R4: duty 128 -> thr 30
        pwm_per = 50; pwm_hi = 25;
        wait_cyc(300);
        count_high(0, 600, c);
        check("R4 remeasured duty", c, 300);

        // R5: code 5 -> P=80
        fdim_code = 3'd5;
        wait_cyc(200);
        rise_gap(0, 0, c);
        check("R5 output period", c, 80);

        // R7: exclusion at start
        en = 1'b0; ch_open = 6'b100000;
        wait_cyc(5);
        en = 1'b1;
        wait_cyc(3);
        ch_open = '0;
        wait_cyc(300);
        count_high(5, 400, c);
        check("R7 excluded channel", c, 0);
        rise_gap(0, 1, c);
        check("R6 spacing N=5", c, 16);

        // R8: short open run is harmless, long one latches
        ch_open = 6'b001000; wait_cyc(20); ch_open = '0;
        wait_cyc(5);
        ch_open = 6'b000100; wait_cyc(40); ch_open = '0;
        wait_cyc(200);
        count_high(2, 400, c);
        check("R8 faulted channel", c, 0);
        count_high(3, 400, c);
        check("R8 short open ignored", c, 200);
        en = 1'b0; wait_cyc(5); en = 1'b1;
        wait_cyc(300);
        count_high(2, 400, c);
        check("R8 fault survives restart", c, 0);
        count_high(5, 400, c);
        check("R7 exclusion recaptured", c, 200);

        // R11: stuck input
        stuck = 2;
        wait_cyc(1300);
        check("R11 stuck high full duty", int'(sink_en), 6'b111011);
        stuck = 1;
        wait_cyc(1300);
        check("R11 stuck low zero duty", int'(sink_en), 0);

        // R10: boost waits for a high PWM after start
        en = 1'b0; wait_cyc(5); en = 1'b1;
        wait_cyc(300);
        check("R10 boost held on 0% PWM", int'(boost_off), 1);
        stuck = 0;
        wait_cyc(60);
        check("R10 boost released on PWM", int'(boost_off), 0);

        // R9: all open at overvoltage
        ch_open = NCH'(ALL); ovp_hit = 1'b1;
        wait_cyc(2);
        ch_open = '0; ovp_hit = 1'b0;
        wait_cyc(5);
        check("R9 sinks off", int'(sink_en), 0);
        check("R9 boost off", int'(boost_off), 1);
        en = 1'b0; wait_cyc(5); en = 1'b1;
        orv = 0; allb = 1;
        repeat (200) begin
            @(negedge clk);
            orv |= int'(sink_en);
            allb &= int'(boost_off);
        end
        check("R9 shutdown sticky sinks", orv, 0);
        check("R9 shutdown sticky boost", allb, 1);

        finish_run();
    end
endmodule